// File: doc/BRIEF.md
# Triggered Acquisition Timing Sequencer

This block decides when samples are taken once an acquisition has been triggered. Once enabled it arms itself and raises a waiting flag. The first trigger pulse that arrives while armed is accepted and flagged with a one-cycle acknowledge, which a later stage can use to capture a timestamp. The block then counts a programmable delay and produces a programmable number of decimated sample periods, each a programmable number of clocks long.

For every period it drives three strobes to a per-channel accumulator. The start strobe clears the accumulator. The integrate strobe adds the current input sample. The done strobe tells the accumulator that its result is complete. With averaging selected, every clock of a period is integrated. Without it, only the first clock of each period is kept.

Triggers that arrive during the delay or the record are ignored. The block arms itself again only after the final done strobe. Dropping the enable abandons any record at once.

Top module: `acq_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle has `trig_wait`, `trig_ack`, `smp_start`, `smp_integrate` and `smp_done` all low.
- R2: While `acq_en` is low, all five outputs are low in that same cycle, trigger pulses produce no acknowledge, and any record in progress is abandoned.
- R3: In the idle state, `trig_wait` rises in the cycle after the first clock edge that sees `acq_en` high. It stays high while the block is armed.
- R4: `trig_ack` is high in exactly those cycles where `trig_wait` and `trig_in` are both high. `trig_wait` is low in the cycle after an acknowledge.
- R5: With a trigger delay of D, the first `smp_start` comes D+1 cycles after the acknowledge cycle.
- R6: A decimation input of M gives periods of M+1 clocks. `smp_start` is high on the first clock of each period. A record-length input of N gives N+1 back-to-back periods.
- R7: With `avg_mode` high, `smp_integrate` is high on every clock of every period. With `avg_mode` low, it is high only on the first clock of each period, together with `smp_start`.
- R8: `smp_done` pulses in the cycle after the last clock of each period, so there are N+1 done pulses per record.
- R9: Trigger pulses during the delay or the record are not acknowledged. `trig_wait` rises again in the cycle after the final `smp_done`.
- R10: With a trigger delay of 0, `smp_start` is high in the cycle right after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acq_en | input | 1 | Acquisition enable |
| trig_delay | input | 16 | Delay in clocks from trigger acceptance to first period |
| rec_len | input | 16 | Decimated samples per record minus one |
| decim | input | 18 | Clocks per decimated sample minus one |
| avg_mode | input | 1 | 1: integrate every clock; 0: keep first sample only |
| trig_in | input | 1 | Trigger pulse |
| trig_wait | output | 1 | Armed and waiting for a trigger |
| trig_ack | output | 1 | Trigger accepted this cycle |
| smp_start | output | 1 | First clock of a decimation period |
| smp_integrate | output | 1 | Accumulate the current sample |
| smp_done | output | 1 | Decimated sample complete |

## Verification
`trig_wait`, `trig_ack`, `smp_start` and `smp_integrate` respond in the same cycle as the enable and trigger inputs. `smp_done` comes one register later, and re-arming adds one more cycle after that done pulse. The start of the record is due D+1 cycles after the acknowledge. The bench drives its inputs just after each falling edge and compares all five outputs a short settle time later, against a model that counts cycles since the acknowledge. It also checks the first-start latency and the number of start, integrate and done pulses for each record.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
    localparam int DLY_W = 16;
    localparam int LEN_W = 16;
    localparam int DEC_W = 18;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_DELAY  = 2'd2,
        ST_SAMPLE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic start;
        logic integ;
        logic done;
    } smp_strobe_t;

    typedef struct packed {
        logic dly_load;
        logic dly_step;
        logic ph_clr;
        logic ph_step;
        logic per_clr;
        logic per_step;
    } cnt_ctrl_t;

    function automatic smp_strobe_t strobe_gate(input smp_strobe_t s, input logic en);
        smp_strobe_t r;
        r.start = s.start & en;
        r.integ = s.integ & en;
        r.done  = s.done  & en;
        return r;
    endfunction
endpackage

// File: rtl/acq_seq_cnt.sv
module acq_seq_cnt #(
    parameter int W        = 8,
    parameter bit COUNT_UP = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         step,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] q_next_step;

    generate
        if (COUNT_UP) begin : g_up
            assign q_next_step = q + ONE;
        end else begin : g_down
            assign q_next_step = q - ONE;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (load) begin
            q <= ld_val;
        end else if (step) begin
            q <= q_next_step;
        end
    end
endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
    import acq_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        acq_en,
    input  logic        trig_in,
    input  logic        avg_mode,
    input  logic        dly_is_zero,
    input  logic        dly_last,
    input  logic        ph_zero,
    input  logic        ph_last,
    input  logic        per_last,
    output logic        trig_wait,
    output logic        trig_ack,
    output smp_strobe_t strobe,
    output cnt_ctrl_t   cctl
);
    seq_state_e state, state_nx;
    logic       done_q;
    logic       accept;
    logic       in_sample;
    smp_strobe_t raw;

    assign in_sample = (state == ST_SAMPLE);
    assign accept    = (state == ST_ARMED) && acq_en && trig_in;
    assign trig_wait = (state == ST_ARMED) && acq_en;
    assign trig_ack  = accept;

    always_comb begin
        state_nx = state;
        if (!acq_en) begin
            state_nx = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:   state_nx = ST_ARMED;
                ST_ARMED:  if (accept) state_nx = dly_is_zero ? ST_SAMPLE : ST_DELAY;
                ST_DELAY:  if (dly_last) state_nx = ST_SAMPLE;
                ST_SAMPLE: if (ph_last && per_last) state_nx = ST_IDLE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            state  <= state_nx;
            done_q <= acq_en && in_sample && ph_last;
        end
    end

    always_comb begin
        raw.start = in_sample && ph_zero;
        raw.integ = in_sample && (avg_mode || ph_zero);
        raw.done  = done_q;
        strobe    = strobe_gate(raw, acq_en);
    end

    always_comb begin
        cctl.dly_load = accept;
        cctl.dly_step = (state == ST_DELAY);
        cctl.ph_clr   = !in_sample || ph_last;
        cctl.ph_step  = in_sample;
        cctl.per_clr  = !in_sample;
        cctl.per_step = in_sample && ph_last;
    end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_seq_pkg::*;
#(
    parameter int DW = DLY_W,
    parameter int LW = LEN_W,
    parameter int MW = DEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acq_en,
    input  logic [DW-1:0] trig_delay,
    input  logic [LW-1:0] rec_len,
    input  logic [MW-1:0] decim,
    input  logic          avg_mode,
    input  logic          trig_in,
    output logic          trig_wait,
    output logic          trig_ack,
    output logic          smp_start,
    output logic          smp_integrate,
    output logic          smp_done
);
    localparam logic [DW-1:0] DLY_ONE = DW'(1);

    smp_strobe_t strobe;
    cnt_ctrl_t   cctl;
    logic [DW-1:0] dly_q;
    logic [MW-1:0] ph_q;
    logic [LW-1:0] per_q;

    acq_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .acq_en      (acq_en),
        .trig_in     (trig_in),
        .avg_mode    (avg_mode),
        .dly_is_zero (trig_delay == '0),
        .dly_last    (dly_q == DLY_ONE),
        .ph_zero     (ph_q == '0),
        .ph_last     (ph_q == decim),
        .per_last    (per_q == rec_len),
        .trig_wait   (trig_wait),
        .trig_ack    (trig_ack),
        .strobe      (strobe),
        .cctl        (cctl)
    );

    acq_seq_cnt #(.W(DW), .COUNT_UP(1'b0)) u_dly (
        .clk(clk), .rst(rst), .clr(1'b0), .load(cctl.dly_load),
        .ld_val(trig_delay), .step(cctl.dly_step), .q(dly_q)
    );

    acq_seq_cnt #(.W(MW), .COUNT_UP(1'b1)) u_phase (
        .clk(clk), .rst(rst), .clr(cctl.ph_clr), .load(1'b0),
        .ld_val('0), .step(cctl.ph_step), .q(ph_q)
    );

    acq_seq_cnt #(.W(LW), .COUNT_UP(1'b1)) u_period (
        .clk(clk), .rst(rst), .clr(cctl.per_clr), .load(1'b0),
        .ld_val('0), .step(cctl.per_step), .q(per_q)
    );

    assign smp_start     = strobe.start;
    assign smp_integrate = strobe.integ;
    assign smp_done      = strobe.done;
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk (
    input logic clk,
    input logic rst,
    input logic acq_en,
    input logic avg_mode,
    input logic trig_in,
    input logic trig_wait,
    input logic trig_ack,
    input logic smp_start,
    input logic smp_integrate,
    input logic smp_done
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !trig_wait && !trig_ack && !smp_start && !smp_integrate && !smp_done);

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acq_en |-> !trig_wait && !trig_ack && !smp_start && !smp_integrate && !smp_done);

    // R4
    ack_needs_wait_chk: assert property (@(posedge clk) disable iff (rst)
        trig_ack |-> trig_wait && trig_in);

    // R4
    ack_disarms_chk: assert property (@(posedge clk) disable iff (rst)
        trig_ack |=> !trig_wait);

    // R7
    start_integrates_chk: assert property (@(posedge clk) disable iff (rst)
        smp_start |-> smp_integrate);

    // R7
    single_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_integrate && !avg_mode) |-> smp_start);

    // R9
    armed_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        trig_wait |-> !smp_start && !smp_integrate && !smp_done);
endmodule

bind acq_sequencer acq_sequencer_chk u_chk (
    .clk(clk), .rst(rst), .acq_en(acq_en), .avg_mode(avg_mode), .trig_in(trig_in),
    .trig_wait(trig_wait), .trig_ack(trig_ack), .smp_start(smp_start),
    .smp_integrate(smp_integrate), .smp_done(smp_done)
);

// File: tb/acq_sequencer_tb_top.sv
module acq_sequencer_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acq_en = 1'b0;
    logic [15:0] trig_delay = '0;
    logic [15:0] rec_len = '0;
    logic [17:0] decim = '0;
    logic avg_mode = 1'b0;
    logic trig_in = 1'b0;
    logic trig_wait, trig_ack, smp_start, smp_integrate, smp_done;

    always #10 clk = ~clk;

    acq_sequencer dut_i (
        .clk(clk), .rst(rst), .acq_en(acq_en), .trig_delay(trig_delay),
        .rec_len(rec_len), .decim(decim), .avg_mode(avg_mode), .trig_in(trig_in),
        .trig_wait(trig_wait), .trig_ack(trig_ack), .smp_start(smp_start),
        .smp_integrate(smp_integrate), .smp_done(smp_done)
    );

    int n_chk = 0, n_err = 0;
    int cfg_d = 0, cfg_dec = 0, cfg_r = 0;
    bit cfg_avg = 0;
    // reference model: armed flag, busy flag, cycles since acknowledge
    bit m_armed = 0, m_busy = 0;
    int m_t = 0;
    // statistics
    int cyc_n = 0, n_ack = 0, n_start = 0, n_int = 0, n_done = 0, ack_at = -1, first_start = -1;
    bit finished = 0;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc_n);
        end
    endtask

    task automatic clear_stats();
        n_ack = 0; n_start = 0; n_int = 0; n_done = 0; ack_at = -1; first_start = -1;
    endtask

    task automatic cyc(input logic r, input logic en, input logic trg);
        int len, last_t, k;
        bit inrec, e_wait, e_ack, e_start, e_int, e_done;
        string tw, ta, ts, ti, td;
        @(negedge clk);
        rst = r; acq_en = en; trig_in = trg;
        trig_delay = 16'(cfg_d); rec_len = 16'(cfg_r); decim = 18'(cfg_dec); avg_mode = cfg_avg;
        #1;
        len    = cfg_dec + 1;
        last_t = cfg_d + 1 + (cfg_r + 1) * len;
        k      = m_t - cfg_d - 1;
        e_wait  = !r && en && m_armed;
        e_ack   = e_wait && trg;
        inrec   = !r && en && m_busy && (m_t >= cfg_d + 1) && (m_t < last_t);
        e_start = inrec && (k % len == 0);
        e_int   = inrec && (cfg_avg || (k % len == 0));
        e_done  = !r && en && m_busy && (m_t >= cfg_d + 1 + len) && (m_t <= last_t) && (k % len == 0);
        if (r) begin
            tw = "R1"; ta = "R1"; ts = "R1"; ti = "R1"; td = "R1";
        end else if (!en) begin
            tw = "R2"; ta = "R2"; ts = "R2"; ti = "R2"; td = "R2";
        end else begin
            tw = "R3"; ta = "R4"; ts = "R6"; ti = "R7"; td = "R8";
        end
        chk(tw, "trig_wait", int'(trig_wait), int'(e_wait));
        chk(ta, "trig_ack", int'(trig_ack), int'(e_ack));
        chk(ts, "smp_start", int'(smp_start), int'(e_start));
        chk(ti, "smp_integrate", int'(smp_integrate), int'(e_int));
        chk(td, "smp_done", int'(smp_done), int'(e_done));
        if (trig_ack) begin n_ack++; ack_at = cyc_n; end
        if (smp_start) begin n_start++; if (first_start < 0) first_start = cyc_n; end
        if (smp_integrate) n_int++;
        if (smp_done) n_done++;
        cyc_n++;
        if (r || !en) begin
            m_armed = 0; m_busy = 0;
        end else if (m_armed) begin
            if (trg) begin m_armed = 0; m_busy = 1; m_t = 1; end
        end else if (m_busy) begin
            if (m_t == last_t) begin m_busy = 0; m_armed = 1; end
            else m_t++;
        end else begin
            m_armed = 1;
        end
    endtask

    // one full record: arm, trigger, run through final done, then check re-arm
    task automatic record(int d, int dec, int r, bit avg, bit hold, string tag);
        int total;
        cfg_d = d; cfg_dec = dec; cfg_r = r; cfg_avg = avg;
        cyc(0, 1, 0);
        cyc(0, 1, 0);
        clear_stats();
        cyc(0, 1, 1);
        total = d + 1 + (r + 1) * (dec + 1);
        for (int i = 1; i <= total; i++) cyc(0, 1, hold);
        chk(tag, "R5 first start latency", first_start - ack_at, d + 1);
        chk(tag, "R6 start count", n_start, r + 1);
        chk(tag, "R7 integrate count", n_int, avg ? (r + 1) * (dec + 1) : (r + 1));
        chk(tag, "R8 done count", n_done, r + 1);
        chk(tag, "R9 single ack per record", n_ack, 1);
        cyc(0, 1, 0);
        chk(tag, "R9 re-armed after final done", int'(trig_wait), 1);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) cyc(1, 1, 1);
        chk("R1", "outputs during reset", int'({trig_wait, trig_ack, smp_start, smp_integrate, smp_done}), 0);
        cyc(0, 1, 0);
        chk("R3", "not yet armed first cycle after reset", int'(trig_wait), 0);
        cyc(0, 1, 0);
        chk("R3", "armed one cycle later", int'(trig_wait), 1);

        record(3, 3, 2, 1'b1, 1'b0, "R5");
        record(0, 0, 0, 1'b0, 1'b0, "R10");
        record(5, 2, 3, 1'b0, 1'b1, "R9");
        record(1, 4, 1, 1'b1, 1'b1, "R7");
        record(0, 1, 4, 1'b0, 1'b0, "R6");

        // R2: drop enable mid-record, pulse triggers while disabled
        cfg_d = 2; cfg_dec = 3; cfg_r = 5; cfg_avg = 1;
        cyc(0, 1, 0);
        cyc(0, 1, 1);
        for (int i = 0; i < 6; i++) cyc(0, 1, 0);
        clear_stats();
        for (int i = 0; i < 5; i++) cyc(0, 0, 1);
        chk("R2", "acks while disabled", n_ack, 0);
        chk("R2", "strobes while disabled", n_start + n_int + n_done, 0);
        cyc(0, 1, 0);
        clear_stats();
        for (int i = 0; i < 8; i++) cyc(0, 1, 0);
        chk("R2", "abandoned record emits nothing", n_start + n_int + n_done, 0);
        chk("R3", "re-armed after enable returns", int'(trig_wait), 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule